// File: doc/BRIEF.md
# Register-Mapped Serial Port with Atomic Bit Aliases

This block is an asynchronous serial transmitter and receiver that software drives through a small word-addressed register window. Characters written to the transmit data register queue in an eight-entry FIFO and leave on the serial output. Framing is fixed at one start bit, eight data bits sent LSB first, no parity and one stop bit. Characters arriving on the serial input are oversampled sixteen times per bit and queued in a second eight-entry FIFO. Software reads them one at a time from the receive data register.

The control register and the status register each have two extra addresses, one that clears and one that sets, so that software can change single bits without a read-modify-write sequence. A receive overrun stops the receiver from storing anything more until software clears the flag. A break request drives the line low for one full frame time after the character in flight has finished, and the hardware then drops the request bit on its own.

Top module: `mmio_uart`

## Requirements
- R1: After reset the mode register reads 0, the status register reads 0x0000_0100 (only the TX-empty bit, bit 8, set), and the serial output is high.
- R2: The mode register sits at 0x00 and the status register at 0x10. Each register's address +4 clears every bit written as one and its address +8 sets every bit written as one. Bits written as zero at either alias keep their value. A write to the base address loads the writable bits directly. In the mode register only bit 15 is writable. In the status register bits 12, 11, 10 and 1 are writable.
- R3: While mode bit 15 (global enable) is 0, the serial output stays high, characters on the serial input are not stored, and queued transmit data is kept. When the bit is set, the queued data is sent.
- R4: The divisor register at 0x40 (16 bits, read back as written) sets the bit time to 16 × (divisor + 1) clock cycles.
- R5: Each transmitted character is a low start bit, eight data bits LSB first and a high stop bit. Writing offset 0x20 queues bits 7:0.
- R6: The transmit FIFO holds 8 characters. Status bit 9 reads 1 when the FIFO is full and bit 8 reads 1 when it is empty. A write to 0x20 while the FIFO is full is dropped.
- R7: Status bit 0 reads 1 while the receive FIFO holds a character. A read of 0x30 returns the oldest character in bits 7:0 and removes it, so characters come out in arrival order.
- R8: A low pulse on the serial input that has ended by the middle of the start bit (eight oversampling ticks) is discarded and stores nothing.
- R9: A character that completes while the receive FIFO is full sets status bit 1 (overrun). While bit 1 is set, no further character is stored. Once software clears the bit, reception resumes.
- R10: Status bit 11 (break) makes the transmitter hold the output low for ten bit times, starting after the current character completes. At the end of the break the hardware clears bit 11.
- R11: Status bit 10 enables transmission and bit 12 enables reception. While bit 10 is 0, the output stays high and the transmit FIFO keeps its contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| ser_rx_i | input | 1 | Serial input, idle high |
| ser_tx_o | output | 1 | Serial output, idle high |

## Verification
A FIFO pointer that slips shows within one character as a repeated, missing or reordered byte on the serial output or in the receive data register. If it corrupts the flags, status bits 9 and 8 go wrong by the next status read. Faults in the bit counters or tick counters show as a wrong bit inside the very next frame, because every data bit is sampled at mid-bit at two different divisor settings. A sticky flag that is wrong, whether overrun or break, shows on the next status read or on a line that stays low for the wrong time. The checker flags these conditions in the cycle they occur: the overrun flag dropping without a status write, data becoming available while overrun is set, and the break flag clearing while the line was not in a break.

// File: rtl/mmio_uart_pkg.sv
package mmio_uart_pkg;

  localparam int unsigned ADDR_W = 8;

  localparam logic [3:0] GRP_MODE = 4'h0;
  localparam logic [3:0] GRP_STAT = 4'h1;
  localparam logic [3:0] GRP_TXD  = 4'h2;
  localparam logic [3:0] GRP_RXD  = 4'h3;
  localparam logic [3:0] GRP_DIV  = 4'h4;

  localparam logic [3:0] KIND_PLAIN = 4'h0;
  localparam logic [3:0] KIND_CLR   = 4'h4;
  localparam logic [3:0] KIND_SET   = 4'h8;

  localparam int unsigned B_EN      = 15;
  localparam int unsigned B_RXEN    = 12;
  localparam int unsigned B_BRK     = 11;
  localparam int unsigned B_TXEN    = 10;
  localparam int unsigned B_TXFULL  = 9;
  localparam int unsigned B_TXEMPTY = 8;
  localparam int unsigned B_OVR     = 1;
  localparam int unsigned B_AVAIL   = 0;

  typedef enum logic [2:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP, TX_BREAK} tx_st_e;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_st_e;

  function automatic logic bit_upd(input logic cur, input logic wb, input logic [3:0] kind);
    logic r;
    case (kind)
      KIND_PLAIN: r = wb;
      KIND_CLR:   r = cur & ~wb;
      KIND_SET:   r = cur | wb;
      default:    r = cur;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/mmio_uart_fifo.sv
module mmio_uart_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp_q, rp_q, wp_d, rp_d;
  logic         do_push, do_pop;

  assign empty   = (wp_q == rp_q);
  assign full    = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp_q[AW-1:0]];

  always_comb begin
    wp_d = wp_q + {{AW{1'b0}}, do_push};
    rp_d = rp_q + {{AW{1'b0}}, do_pop};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      wp_q <= wp_d;
      rp_q <= rp_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q[AW-1:0]] <= din;
  end
endmodule

// File: rtl/mmio_uart_tick.sv
module mmio_uart_tick #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q >= div);

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + {{(DIV_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/mmio_uart_tx.sv
module mmio_uart_tx
  import mmio_uart_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       tick,
  input  logic       have_data,
  input  logic [7:0] data,
  input  logic       brk_req,
  output logic       pop,
  output logic       brk_done,
  output logic       tx_o
);
  tx_st_e     st_q, st_d;
  logic [3:0] tck_q, tck_d;
  logic [3:0] bit_q, bit_d;
  logic [7:0] sh_q, sh_d;
  logic       line_q, line_d;
  logic       last_tck;

  assign tx_o     = line_q;
  assign last_tck = (tck_q == 4'd15);

  always_comb begin
    st_d     = st_q;
    tck_d    = tck_q;
    bit_d    = bit_q;
    sh_d     = sh_q;
    line_d   = line_q;
    pop      = 1'b0;
    brk_done = 1'b0;
    if (!run) begin
      st_d   = TX_IDLE;
      tck_d  = '0;
      bit_d  = '0;
      line_d = 1'b1;
    end else if (tick) begin
      tck_d = tck_q + 4'd1;
      case (st_q)
        TX_IDLE: begin
          tck_d = '0;
          bit_d = '0;
          if (brk_req) begin
            st_d   = TX_BREAK;
            line_d = 1'b0;
          end else if (have_data) begin
            pop    = 1'b1;
            sh_d   = data;
            st_d   = TX_START;
            line_d = 1'b0;
          end
        end
        TX_START: if (last_tck) begin
          st_d   = TX_DATA;
          line_d = sh_q[0];
        end
        TX_DATA: if (last_tck) begin
          if (bit_q == 4'd7) begin
            st_d   = TX_STOP;
            line_d = 1'b1;
          end else begin
            bit_d  = bit_q + 4'd1;
            sh_d   = {1'b0, sh_q[7:1]};
            line_d = sh_q[1];
          end
        end
        TX_STOP: if (last_tck) st_d = TX_IDLE;
        TX_BREAK: if (last_tck) begin
          if (bit_q == 4'd9) begin
            st_d     = TX_IDLE;
            line_d   = 1'b1;
            brk_done = 1'b1;
          end else begin
            bit_d = bit_q + 4'd1;
          end
        end
        default: st_d = TX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TX_IDLE;
      tck_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      line_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      tck_q  <= tck_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      line_q <= line_d;
    end
  end
endmodule

// File: rtl/mmio_uart_rx.sv
module mmio_uart_rx
  import mmio_uart_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       tick,
  input  logic       rx_i,
  output logic       valid,
  output logic [7:0] data
);
  rx_st_e     st_q, st_d;
  logic [3:0] tck_q, tck_d;
  logic [2:0] bit_q, bit_d;
  logic [7:0] sh_q, sh_d;
  logic [1:0] sync_q;
  logic       rx_s;

  assign rx_s = sync_q[1];
  assign data = sh_q;

  always_comb begin
    st_d  = st_q;
    tck_d = tck_q;
    bit_d = bit_q;
    sh_d  = sh_q;
    valid = 1'b0;
    if (!run) begin
      st_d  = RX_IDLE;
      tck_d = '0;
    end else if (tick) begin
      tck_d = tck_q + 4'd1;
      case (st_q)
        RX_IDLE: begin
          tck_d = '0;
          if (!rx_s) st_d = RX_START;
        end
        RX_START: if (tck_q == 4'd7) begin
          tck_d = '0;
          bit_d = '0;
          st_d  = rx_s ? RX_IDLE : RX_DATA;
        end
        RX_DATA: if (tck_q == 4'd15) begin
          tck_d = '0;
          sh_d  = {rx_s, sh_q[7:1]};
          if (bit_q == 3'd7) st_d = RX_STOP;
          else               bit_d = bit_q + 3'd1;
        end
        RX_STOP: if (tck_q == 4'd15) begin
          tck_d = '0;
          st_d  = RX_IDLE;
          valid = rx_s;
        end
        default: st_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      tck_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      sync_q <= 2'b11;
    end else begin
      st_q   <= st_d;
      tck_q  <= tck_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      sync_q <= {sync_q[0], rx_i};
    end
  end
endmodule

// File: rtl/mmio_uart.sv
module mmio_uart
  import mmio_uart_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 8,
  parameter int unsigned DIV_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              ser_rx_i,
  output logic              ser_tx_o
);
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic [3:0] grp, kind;
  logic       wr, rd, wr_mode, wr_stat, wr_txd, wr_div, rd_rxd;
  assign grp     = bus_addr[7:4];
  assign kind    = bus_addr[3:0];
  assign wr      = bus_sel && bus_we;
  assign rd      = bus_sel && !bus_we;
  assign wr_mode = wr && (grp == GRP_MODE);
  assign wr_stat = wr && (grp == GRP_STAT);
  assign wr_txd  = wr && (grp == GRP_TXD) && (kind == KIND_PLAIN);
  assign wr_div  = wr && (grp == GRP_DIV) && (kind == KIND_PLAIN);
  assign rd_rxd  = rd && (grp == GRP_RXD) && (kind == KIND_PLAIN);

  logic             mode_en_q, rxen_q, brk_q, txen_q, ovr_q;
  logic             mode_en_d, rxen_d, brk_d, txen_d, ovr_d;
  logic [DIV_W-1:0] div_q, div_d;

  logic       tick, tx_run, rx_run;
  logic       tx_full, tx_empty, tx_pop, brk_done;
  logic [7:0] tx_head;
  logic       rx_full, rx_empty, rx_valid, rx_push, ovr_set, rx_avail;
  logic [7:0] rx_byte, rx_head;

  assign tx_run   = mode_en_q && txen_q;
  assign rx_run   = mode_en_q && rxen_q;
  assign rx_avail = !rx_empty;
  assign rx_push  = rx_valid && !rx_full && !ovr_q;
  assign ovr_set  = rx_valid && rx_full;

  always_comb begin
    mode_en_d = mode_en_q;
    rxen_d    = rxen_q;
    txen_d    = txen_q;
    brk_d     = brk_done ? 1'b0 : brk_q;
    ovr_d     = ovr_q;
    div_d     = div_q;
    if (wr_mode) mode_en_d = bit_upd(mode_en_q, bus_wdata[B_EN], kind);
    if (wr_stat) begin
      rxen_d = bit_upd(rxen_q, bus_wdata[B_RXEN], kind);
      txen_d = bit_upd(txen_q, bus_wdata[B_TXEN], kind);
      brk_d  = bit_upd(brk_d,  bus_wdata[B_BRK],  kind);
      ovr_d  = bit_upd(ovr_q,  bus_wdata[B_OVR],  kind);
    end
    if (ovr_set) ovr_d = 1'b1;
    if (wr_div) div_d = bus_wdata[DIV_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mode_en_q <= 1'b0;
      rxen_q    <= 1'b0;
      txen_q    <= 1'b0;
      brk_q     <= 1'b0;
      ovr_q     <= 1'b0;
      div_q     <= '0;
    end else begin
      mode_en_q <= mode_en_d;
      rxen_q    <= rxen_d;
      txen_q    <= txen_d;
      brk_q     <= brk_d;
      ovr_q     <= ovr_d;
      div_q     <= div_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (kind == KIND_PLAIN) begin
      case (grp)
        GRP_MODE: bus_rdata[B_EN] = mode_en_q;
        GRP_STAT: begin
          bus_rdata[B_RXEN]    = rxen_q;
          bus_rdata[B_BRK]     = brk_q;
          bus_rdata[B_TXEN]    = txen_q;
          bus_rdata[B_TXFULL]  = tx_full;
          bus_rdata[B_TXEMPTY] = tx_empty;
          bus_rdata[B_OVR]     = ovr_q;
          bus_rdata[B_AVAIL]   = rx_avail;
        end
        GRP_RXD: bus_rdata[7:0] = rx_avail ? rx_head : 8'h00;
        GRP_DIV: bus_rdata[DIV_W-1:0] = div_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  mmio_uart_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_sync_n), .run(mode_en_q), .div(div_q), .tick(tick)
  );

  mmio_uart_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_sync_n), .push(wr_txd), .pop(tx_pop),
    .din(bus_wdata[7:0]), .dout(tx_head), .full(tx_full), .empty(tx_empty)
  );

  mmio_uart_tx u_tx (
    .clk(clk), .rst_n(rst_sync_n), .run(tx_run), .tick(tick),
    .have_data(!tx_empty), .data(tx_head), .brk_req(brk_q),
    .pop(tx_pop), .brk_done(brk_done), .tx_o(ser_tx_o)
  );

  mmio_uart_rx u_rx (
    .clk(clk), .rst_n(rst_sync_n), .run(rx_run), .tick(tick),
    .rx_i(ser_rx_i), .valid(rx_valid), .data(rx_byte)
  );

  mmio_uart_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_sync_n), .push(rx_push), .pop(rd_rxd),
    .din(rx_byte), .dout(rx_head), .full(rx_full), .empty(rx_empty)
  );
endmodule

// File: rtl/mmio_uart_chk.sv
module mmio_uart_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_sel,
  input logic       bus_we,
  input logic [7:0] bus_addr,
  input logic       mode_en,
  input logic       brk,
  input logic       ovr,
  input logic       avail,
  input logic       tx_full,
  input logic       tx_empty,
  input logic       tx_o
);
  logic stat_wr;
  assign stat_wr = bus_sel && bus_we && (bus_addr[7:4] == 4'h1);

  assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_full && tx_empty));

  assert_idle_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en |=> tx_o);

  assert_ovr_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !stat_wr) |=> ovr);

  assert_ovr_blocks_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !avail) |=> !avail);

  assert_brk_selfclear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(brk) && !$past(stat_wr)) |-> !$past(tx_o));
endmodule

bind mmio_uart mmio_uart_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .mode_en(mode_en_q), .brk(brk_q), .ovr(ovr_q),
  .avail(rx_avail), .tx_full(tx_full), .tx_empty(tx_empty), .tx_o(ser_tx_o)
);

// File: tb/sim_mmio_uart.sv
module sim_mmio_uart;
  logic        clk;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        ser_rx;
  logic        ser_tx;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  mmio_uart u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ser_rx_i(ser_rx), .ser_tx_o(ser_tx)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic get_frame(input int bitclk, output logic [7:0] b, output logic ok);
    int w;
    w = 0; ok = 1'b1; b = '0;
    while (ser_tx === 1'b1 && w < 4000) begin @(negedge clk); w++; end
    if (w >= 4000) begin ok = 1'b0; return; end
    repeat (bitclk / 2) @(negedge clk);
    if (ser_tx !== 1'b0) ok = 1'b0;
    for (int i = 0; i < 8; i++) begin
      repeat (bitclk) @(negedge clk);
      b[i] = ser_tx;
    end
    repeat (bitclk) @(negedge clk);
    if (ser_tx !== 1'b1) ok = 1'b0;
  endtask

  task automatic send_rx(input logic [7:0] b);
    @(negedge clk); ser_rx = 1'b0;
    repeat (16) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      ser_rx = b[i];
      repeat (16) @(negedge clk);
    end
    ser_rx = 1'b1;
    repeat (16) @(negedge clk);
  endtask

  task automatic tx_quiet(input int n, output logic q);
    q = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (ser_tx !== 1'b1) q = 1'b0;
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    bus_read(8'h00, d); chk("R1 mode after reset", d, 32'h0);
    bus_read(8'h10, d); chk("R1 status after reset", d, 32'h100);
    chk("R1 line idle after reset", {31'b0, ser_tx}, 32'h1);
  endtask

  task automatic t_alias;
    logic [31:0] d;
    bus_write(8'h00, 32'h8000); bus_read(8'h00, d); chk("R2 mode plain write", d, 32'h8000);
    bus_write(8'h04, 32'h0);    bus_read(8'h00, d); chk("R2 zero at clear alias", d, 32'h8000);
    bus_write(8'h04, 32'h8000); bus_read(8'h00, d); chk("R2 mode clear alias", d, 32'h0);
    bus_write(8'h08, 32'hFFFF_FFFF); bus_read(8'h00, d); chk("R2 mode set alias", d, 32'h8000);
    bus_write(8'h18, 32'h1400); bus_read(8'h10, d); chk("R2 status set alias", d, 32'h1500);
    bus_write(8'h14, 32'h0);    bus_read(8'h10, d); chk("R2 zero at status clear", d, 32'h1500);
    bus_write(8'h14, 32'h1000); bus_read(8'h10, d); chk("R2 status clear alias", d, 32'h0500);
    bus_write(8'h10, 32'h0);
    bus_write(8'h04, 32'h8000);
  endtask

  task automatic t_tx;
    logic [31:0] d; logic [7:0] b; logic ok;
    bus_write(8'h40, 32'h2); bus_read(8'h40, d); chk("R4 divisor readback", d, 32'h2);
    bus_write(8'h40, 32'h0);
    bus_write(8'h08, 32'h8000);
    bus_write(8'h18, 32'h1400);
    bus_write(8'h20, 32'hA5);
    get_frame(16, b, ok);
    chk("R5 frame shape div0", {31'b0, ok}, 32'h1);
    chk("R5 frame data div0", {24'b0, b}, 32'hA5);
    repeat (20) @(negedge clk);
    bus_write(8'h40, 32'h2);
    bus_write(8'h20, 32'h3C);
    get_frame(48, b, ok);
    chk("R4 frame shape div2", {31'b0, ok}, 32'h1);
    chk("R4 frame data div2", {24'b0, b}, 32'h3C);
    repeat (60) @(negedge clk);
    bus_write(8'h40, 32'h0);
  endtask

  task automatic t_fifo;
    logic [31:0] d; logic [7:0] b; logic ok; logic q;
    bus_write(8'h14, 32'h400);
    for (int i = 0; i < 9; i++) bus_write(8'h20, 32'h10 + i);
    bus_read(8'h10, d); chk("R6 full and not empty", d & 32'h300, 32'h200);
    tx_quiet(100, q); chk("R11 line high while tx disabled", {31'b0, q}, 32'h1);
    bus_write(8'h18, 32'h400);
    for (int i = 0; i < 8; i++) begin
      get_frame(16, b, ok);
      chk("R6 queued frame ok", {31'b0, ok}, 32'h1);
      chk("R11 queued data kept in order", {24'b0, b}, 32'h10 + i);
    end
    tx_quiet(300, q); chk("R6 ninth write dropped", {31'b0, q}, 32'h1);
    bus_read(8'h10, d); chk("R6 empty after drain", d & 32'h300, 32'h100);
  endtask

  task automatic t_rx;
    logic [31:0] d;
    send_rx(8'h5A);
    bus_read(8'h10, d); chk("R7 data available", d & 32'h1, 32'h1);
    bus_read(8'h30, d); chk("R7 received byte", d, 32'h5A);
    bus_read(8'h10, d); chk("R7 empty after pop", d & 32'h1, 32'h0);
    send_rx(8'h11); send_rx(8'h22);
    bus_read(8'h30, d); chk("R7 oldest first", d, 32'h11);
    bus_read(8'h30, d); chk("R7 second byte", d, 32'h22);
  endtask

  task automatic t_false;
    logic [31:0] d;
    @(negedge clk); ser_rx = 1'b0;
    repeat (4) @(negedge clk); ser_rx = 1'b1;
    repeat (300) @(negedge clk);
    bus_read(8'h10, d); chk("R8 glitch not stored", d & 32'h1, 32'h0);
    send_rx(8'h77);
    bus_read(8'h30, d); chk("R8 receiver recovers", d, 32'h77);
  endtask

  task automatic t_ovr;
    logic [31:0] d;
    for (int i = 0; i < 9; i++) send_rx(8'h40 + i);
    bus_read(8'h10, d); chk("R9 overrun set", d & 32'h3, 32'h3);
    send_rx(8'h49);
    for (int i = 0; i < 8; i++) begin
      bus_read(8'h30, d); chk("R9 stored bytes before overrun", d, 32'h40 + i);
    end
    bus_read(8'h10, d); chk("R9 nothing stored during overrun", d & 32'h3, 32'h2);
    bus_write(8'h14, 32'h2);
    bus_read(8'h10, d); chk("R9 overrun cleared", d & 32'h2, 32'h0);
    send_rx(8'h4A);
    bus_read(8'h30, d); chk("R9 reception resumes", d, 32'h4A);
  endtask

  task automatic t_brk;
    logic [31:0] d; logic [7:0] b; logic ok; int w;
    bus_write(8'h20, 32'h81);
    bus_write(8'h18, 32'h800);
    get_frame(16, b, ok);
    chk("R10 char before break", {23'b0, ok, b}, 32'h181);
    w = 0;
    while (ser_tx === 1'b1 && w < 400) begin @(negedge clk); w++; end
    repeat (80) @(negedge clk);
    chk("R10 line low mid break", {31'b0, ser_tx}, 32'h0);
    bus_read(8'h10, d); chk("R10 flag held during break", d & 32'h800, 32'h800);
    repeat (66) @(negedge clk);
    chk("R10 line low near end", {31'b0, ser_tx}, 32'h0);
    repeat (22) @(negedge clk);
    chk("R10 line high after break", {31'b0, ser_tx}, 32'h1);
    bus_read(8'h10, d); chk("R10 flag self cleared", d & 32'h800, 32'h0);
  endtask

  task automatic t_disable;
    logic [31:0] d; logic [7:0] b; logic ok; logic q;
    bus_write(8'h04, 32'h8000);
    bus_write(8'h20, 32'h55);
    tx_quiet(300, q); chk("R3 line high while disabled", {31'b0, q}, 32'h1);
    send_rx(8'h66);
    bus_read(8'h10, d); chk("R3 nothing received while disabled", d & 32'h1, 32'h0);
    bus_write(8'h08, 32'h8000);
    get_frame(16, b, ok);
    chk("R3 queued byte sent after enable", {23'b0, ok, b}, 32'h155);
  endtask

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; ser_rx = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_alias;
    t_tx;
    t_fifo;
    t_rx;
    t_false;
    t_ovr;
    t_brk;
    t_disable;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule